// File: doc/BRIEF.md
# Output Shutdown Protection Controller

This block guards six high-current output drivers, grouped as three complementary pairs. Each pair should never drive low on both pins at once. If both pins of any pair are low together for two or more consecutive sampled clocks, the block latches a fault and turns off the output enable of all six drivers. Four active-low external request pins can force the same shutdown. Each request pin has its own detection mode, chosen from a sampled low level, a falling edge, or a low level held for a short or a long count.

Every detection sets a sticky flag. The drivers stay off until software has cleared every set flag, and a flag can only be cleared by writing 0 to it after a read that returned it as 1. One interrupt line is raised when any flag is set whose interrupt enable is also set. The timer that produces the pair waveforms sits outside this block, and so do the pads; this block only gates their enables.

Top module: `pairFaultGuard`

## Requirements
- R1: After reset both registers read 0, all six `pinOe` bits are 1 and `irq` is 0.
- R2: With comparison enabled (bit 0 of register 1), when both pins of any pair are sampled low on two or more consecutive clocks, flag bit 15 of register 1 is set and all six `pinOe` bits go to 0. A low-low lasting exactly one sampled clock sets nothing.
- R3: With comparison disabled, a low-low of any length sets no flag and leaves `pinOe` all 1.
- R4: Request mode 00 (level): a single sampled low on request pin i sets flag bit 12+i of register 0. The mode for pin i is held in bits 2i+1:2i of register 0.
- R5: Request mode 01 (falling edge): a high-to-low change on pin i sets its flag. A pin that was already low when this mode was selected sets nothing.
- R6: Request mode 10: pin i sets its flag only after HOLD_SHORT (8) consecutive sampled lows. A run of 7 sets nothing.
- R7: Request mode 11: pin i sets its flag only after HOLD_LONG (16) consecutive sampled lows. A run of 15 sets nothing.
- R8: Writing 0 to a set flag clears it only if a read has returned that flag as 1. Writing 1 to a flag has no effect.
- R9: `pinOe` stays all 0 while any flag is set, and returns to all 1 only once every flag is clear.
- R10: `irq` is 1 exactly when some flag is set and its enable is 1. The enables are bit 8+i of register 0 for request pin i, and bit 1 of register 1 for the comparison flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 1 | Register select: 0 = input control/status, 1 = output control/status |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; arms clearing of the flags it returns as 1 |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register (combinational) |
| reqPinN | input | 4 | Active-low external shutdown requests |
| pairA | input | 3 | First driver of each complementary pair |
| pairB | input | 3 | Second driver of each complementary pair |
| pinOe | output | 6 | Output enables; bit 2k is pair k pin A, bit 2k+1 is pair k pin B |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a partial release: two flags set at once, with only one of them armed-and-cleared, while the drivers must stay off. The bench sets two request flags with separate pulses, reads the register once to arm both, and then writes a value that keeps one flag bit at 1. This lets it observe that `pinOe` stays low and that `irq` follows only the flag that is still enabled. The boundary runs of the hold modes (7 against 8 sampled lows, 15 against 16) and the one-clock low-low are driven with cycle-exact pulses from a vector table.

// File: rtl/pfgPkg.sv
`timescale 1ns/1ps
package pfgPkg;
  localparam int NUM_REQ  = 4;
  localparam int NUM_PAIR = 3;
  localparam int REG_W    = 16;

  typedef enum logic [1:0] {
    MODE_LEVEL  = 2'b00,
    MODE_FALL   = 2'b01,
    MODE_HOLD_S = 2'b10,
    MODE_HOLD_L = 2'b11
  } reqMode_e;

  // configuration from control to datapath
  typedef struct packed {
    logic [NUM_REQ-1:0][1:0] mode;
    logic                    cmpEn;
  } detCfg_t;

  // detection strobes from datapath to control
  typedef struct packed {
    logic [NUM_REQ-1:0] reqHit;
    logic               cmpHit;
  } hitStrobe_t;
endpackage

// File: rtl/pfgDetect.sv
`timescale 1ns/1ps
module pfgDetect
  import pfgPkg::*;
#(
  parameter int HOLD_SHORT = 8,
  parameter int HOLD_LONG  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REQ-1:0]  reqPinN,
  input  logic [NUM_PAIR-1:0] pairA,
  input  logic [NUM_PAIR-1:0] pairB,
  input  detCfg_t             cfg,
  output hitStrobe_t          hit
);
  localparam int CW = $clog2(HOLD_LONG + 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(HOLD_SHORT - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(HOLD_LONG - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(HOLD_LONG);

  logic [NUM_REQ-1:0]  reqQ, reqPrevQ, reqHitVec;
  logic [NUM_PAIR-1:0] bothLowRaw, bothLowQ, bothLowPrevQ;

  assign bothLowRaw = ~pairA & ~pairB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ         <= '1;
      reqPrevQ     <= '1;
      bothLowQ     <= '0;
      bothLowPrevQ <= '0;
    end else begin
      reqQ         <= reqPinN;
      reqPrevQ     <= reqQ;
      bothLowQ     <= bothLowRaw;
      bothLowPrevQ <= bothLowQ;
    end
  end

  for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_req
    logic [CW-1:0] lowCnt;   // sampled lows before the current one
    reqMode_e      modeSel;

    assign modeSel = reqMode_e'(cfg.mode[gi]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           lowCnt <= '0;
      else if (reqQ[gi])   lowCnt <= '0;
      else if (lowCnt != CNT_SAT) lowCnt <= lowCnt + 1'b1;
    end

    assign reqHitVec[gi] =
        (modeSel == MODE_LEVEL)  ? ~reqQ[gi] :
        (modeSel == MODE_FALL)   ? (reqPrevQ[gi] & ~reqQ[gi]) :
        (modeSel == MODE_HOLD_S) ? (~reqQ[gi] && lowCnt >= SHORT_M1) :
                                   (~reqQ[gi] && lowCnt >= LONG_M1);
  end

  assign hit.reqHit = reqHitVec;
  assign hit.cmpHit = cfg.cmpEn & |(bothLowQ & bothLowPrevQ);

  // R2: a pair fault needs a low-low seen at the pins on two consecutive edges
  p_lowlow_two_r2: assert property (@(posedge clk) disable iff (!rstN)
    hit.cmpHit |-> ($past(|bothLowRaw, 1) && $past(|bothLowRaw, 2)));
endmodule

// File: rtl/pfgRegs.sv
`timescale 1ns/1ps
module pfgRegs
  import pfgPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regAddr,
  input  logic                    regWr,
  input  logic                    regRd,
  input  logic [REG_W-1:0]        regWrData,
  output logic [REG_W-1:0]        regRdData,
  input  hitStrobe_t              hit,
  output detCfg_t                 cfg,
  output logic [2*NUM_PAIR-1:0]   pinOe,
  output logic                    irq
);
  localparam int MODE_LSB = 0;
  localparam int IEN_LSB  = 2 * NUM_REQ;
  localparam int FLAG_LSB = IEN_LSB + NUM_REQ;
  localparam int CMP_EN_BIT  = 0;
  localparam int CMP_IEN_BIT = 1;
  localparam int CMP_FLAG_BIT = REG_W - 1;

  logic [2*NUM_REQ-1:0] modeQ;
  logic [NUM_REQ-1:0]   reqIenQ, reqFlagQ, reqArmQ;
  logic [NUM_REQ-1:0]   reqClr, reqFlagD, reqArmD;
  logic cmpEnQ, cmpIenQ, cmpFlagQ, cmpArmQ;
  logic cmpClr, cmpFlagD, cmpArmD;
  logic wrIn, wrOut, rdIn, rdOut, anyFlag;

  assign wrIn  = regWr && !regAddr;
  assign wrOut = regWr &&  regAddr;
  assign rdIn  = regRd && !regAddr;
  assign rdOut = regRd &&  regAddr;

  // clear needs a prior read that returned the flag set; new hits win
  assign reqClr   = {NUM_REQ{wrIn}} & ~regWrData[FLAG_LSB +: NUM_REQ] & reqArmQ;
  assign reqFlagD = hit.reqHit | (reqFlagQ & ~reqClr);
  assign reqArmD  = reqFlagD & ~reqClr & (reqArmQ | ({NUM_REQ{rdIn}} & reqFlagQ));

  assign cmpClr   = wrOut && !regWrData[CMP_FLAG_BIT] && cmpArmQ;
  assign cmpFlagD = hit.cmpHit | (cmpFlagQ & ~cmpClr);
  assign cmpArmD  = cmpFlagD & ~cmpClr & (cmpArmQ | (rdOut & cmpFlagQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= '0;
      reqIenQ  <= '0;
      reqFlagQ <= '0;
      reqArmQ  <= '0;
      cmpEnQ   <= 1'b0;
      cmpIenQ  <= 1'b0;
      cmpFlagQ <= 1'b0;
      cmpArmQ  <= 1'b0;
    end else begin
      if (wrIn) begin
        modeQ   <= regWrData[MODE_LSB +: 2*NUM_REQ];
        reqIenQ <= regWrData[IEN_LSB +: NUM_REQ];
      end
      if (wrOut) begin
        cmpEnQ  <= regWrData[CMP_EN_BIT];
        cmpIenQ <= regWrData[CMP_IEN_BIT];
      end
      reqFlagQ <= reqFlagD;
      reqArmQ  <= reqArmD;
      cmpFlagQ <= cmpFlagD;
      cmpArmQ  <= cmpArmD;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData[CMP_EN_BIT]   = cmpEnQ;
      regRdData[CMP_IEN_BIT]  = cmpIenQ;
      regRdData[CMP_FLAG_BIT] = cmpFlagQ;
    end else begin
      regRdData[MODE_LSB +: 2*NUM_REQ] = modeQ;
      regRdData[IEN_LSB +: NUM_REQ]    = reqIenQ;
      regRdData[FLAG_LSB +: NUM_REQ]   = reqFlagQ;
    end
  end

  assign cfg.mode  = modeQ;
  assign cfg.cmpEn = cmpEnQ;
  assign anyFlag   = |reqFlagQ | cmpFlagQ;
  assign pinOe     = {2*NUM_PAIR{~anyFlag}};
  assign irq       = |(reqFlagQ & reqIenQ) | (cmpFlagQ & cmpIenQ);

  // R8: flags never drop without a register write
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> (((reqFlagQ & $past(reqFlagQ)) == $past(reqFlagQ)) &&
                (cmpFlagQ || !$past(cmpFlagQ))));

  // R3: comparison flag only rises while comparison was enabled
  p_cmp_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlagQ) |-> $past(cmpEnQ));

  // R9: outputs come back only right after a write
  p_oe_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinOe[0]) |-> $past(regWr));

  // R10: interrupt only with some enable set
  p_irq_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|reqIenQ || cmpIenQ));
endmodule

// File: rtl/pairFaultGuard.sv
`timescale 1ns/1ps
module pairFaultGuard
  import pfgPkg::*;
#(
  parameter int HOLD_SHORT = 8,
  parameter int HOLD_LONG  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic [NUM_REQ-1:0]    reqPinN,
  input  logic [NUM_PAIR-1:0]   pairA,
  input  logic [NUM_PAIR-1:0]   pairB,
  output logic [2*NUM_PAIR-1:0] pinOe,
  output logic                  irq
);
  detCfg_t    cfg;
  hitStrobe_t hit;

  pfgDetect #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) i_detect (
    .clk(clk), .rstN(rstN), .reqPinN(reqPinN),
    .pairA(pairA), .pairB(pairB), .cfg(cfg), .hit(hit)
  );

  pfgRegs i_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .hit(hit), .cfg(cfg),
    .pinOe(pinOe), .irq(irq)
  );
endmodule

// File: tb/test_pairFaultGuard.sv
`timescale 1ns/1ps
module test_pairFaultGuard;
  localparam real HALF = 2.5;
  localparam int  NV = 9;
  // {idx[1:0], mode[1:0], len[7:0], expectFlag}
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 2'b00, 8'd1,  1'b1},
    {2'd1, 2'b00, 8'd3,  1'b1},
    {2'd2, 2'b10, 8'd7,  1'b0},
    {2'd2, 2'b10, 8'd8,  1'b1},
    {2'd3, 2'b11, 8'd15, 1'b0},
    {2'd3, 2'b11, 8'd16, 1'b1},
    {2'd0, 2'b11, 8'd20, 1'b1},
    {2'd1, 2'b01, 8'd1,  1'b1},
    {2'd2, 2'b01, 8'd4,  1'b1}
  };

  logic        clk = 0, rstN = 0;
  logic        regAddr = 0, regWr = 0, regRd = 0;
  logic [15:0] regWrData = '0, regRdData;
  logic [3:0]  reqPinN = 4'hF;
  logic [2:0]  pairA = 3'b111, pairB = 3'b000;
  logic [5:0]  pinOe;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  pairFaultGuard i_pairFaultGuard (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .reqPinN(reqPinN),
    .pairA(pairA), .pairB(pairB), .pinOe(pinOe), .irq(irq)
  );

  always #(HALF) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rdReg(input logic a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1;
    #1 v = regRdData;
    @(negedge clk);
    regRd = 0;
  endtask

  task automatic pulseReq(input int idx, input int len);
    @(negedge clk);
    reqPinN[idx] = 1'b0;
    repeat (len) @(negedge clk);
    reqPinN[idx] = 1'b1;
  endtask

  task automatic pulsePair(input int k, input int len);
    @(negedge clk);
    pairA[k] = 1'b0;
    repeat (len) @(negedge clk);
    pairA[k] = 1'b1;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, cfgWord;
    steps(3);
    rstN = 1;
    steps(2);

    // R1 reset state
    rdReg(1'b0, v); chk("R1 reg0", v, 16'h0000);
    rdReg(1'b1, v); chk("R1 reg1", v, 16'h0000);
    chk("R1 pinOe", pinOe, 6'h3f);
    chk("R1 irq", irq, 1'b0);

    // R2 comparison: one-cycle low-low ignored, two cycles latch
    wrReg(1'b1, 16'h0001);
    pulsePair(1, 1); steps(3);
    rdReg(1'b1, v); chk("R2 single lowlow flag", v[15], 1'b0);
    chk("R2 single lowlow pinOe", pinOe, 6'h3f);
    pulsePair(1, 2); steps(3);
    chk("R2 lowlow pinOe", pinOe, 6'h00);
    chk("R10 irq disabled", irq, 1'b0);
    wrReg(1'b1, 16'h8003);
    rdReg(1'b1, v); chk("R8 write1 keeps flag", v, 16'h8003);
    chk("R10 irq cmp", irq, 1'b1);
    wrReg(1'b1, 16'h0003); steps(1);
    rdReg(1'b1, v); chk("R8 cmp cleared", v, 16'h0003);
    chk("R9 pinOe restored", pinOe, 6'h3f);
    chk("R10 irq cleared", irq, 1'b0);

    // R3 comparison disabled
    wrReg(1'b1, 16'h0000);
    pulsePair(2, 5); steps(3);
    rdReg(1'b1, v); chk("R3 no flag", v, 16'h0000);
    chk("R3 pinOe", pinOe, 6'h3f);

    // vector table: request modes R4..R7
    for (int n = 0; n < NV; n++) begin
      int idx, len;
      logic [1:0] md;
      logic ex;
      string tag;
      idx = int'(VEC[n][12:11]); md = VEC[n][10:9];
      len = int'(VEC[n][8:1]); ex = VEC[n][0];
      tag = (md == 2'b00) ? "R4" : (md == 2'b01) ? "R5" : (md == 2'b10) ? "R6" : "R7";
      cfgWord = 16'hF000 | (16'(md) << (2 * idx));
      wrReg(1'b0, cfgWord); steps(2);
      pulseReq(idx, len); steps(3);
      rdReg(1'b0, v);
      chk({tag, " flag"}, v[12 + idx], ex);
      chk({tag, " pinOe"}, pinOe, ex ? 6'h00 : 6'h3f);
      wrReg(1'b0, cfgWord & 16'h0FFF); steps(1);
      rdReg(1'b0, v); chk({tag, " cleared"}, v[15:12], 4'h0);
    end

    // R5 pin already low when falling mode selected
    wrReg(1'b0, 16'hF080);
    @(negedge clk); reqPinN[3] = 1'b0;
    steps(3);
    wrReg(1'b0, 16'hF040); steps(4);
    rdReg(1'b0, v); chk("R5 held low no edge", v[15], 1'b0);
    chk("R5 pinOe", pinOe, 6'h3f);
    @(negedge clk); reqPinN[3] = 1'b1; steps(3);
    rdReg(1'b0, v); chk("R5 rising no flag", v[15], 1'b0);

    // R8 write 0 without prior read is ignored
    wrReg(1'b0, 16'hF000);
    pulseReq(0, 1); steps(3);
    wrReg(1'b0, 16'h0000); steps(1);
    rdReg(1'b0, v); chk("R8 unread clear ignored", v[12], 1'b1);
    wrReg(1'b0, 16'h0000); steps(1);
    rdReg(1'b0, v); chk("R8 clear after read", v[12], 1'b0);

    // R9/R10 partial release with two flags
    wrReg(1'b0, 16'hF200);
    pulseReq(1, 1); pulseReq(2, 1); steps(3);
    chk("R10 irq enabled flag", irq, 1'b1);
    rdReg(1'b0, v); chk("R9 two flags", v[15:12], 4'h6);
    wrReg(1'b0, 16'h4200); steps(1);
    rdReg(1'b0, v); chk("R8 partial clear", v[15:12], 4'h4);
    chk("R9 still off", pinOe, 6'h00);
    chk("R10 irq unenabled flag", irq, 1'b0);
    wrReg(1'b0, 16'h0200); steps(1);
    rdReg(1'b0, v); chk("R9 all clear", v[15:12], 4'h0);
    chk("R9 pinOe back", pinOe, 6'h3f);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule